// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Policy Controller

This block owns the row buffer of a single DRAM bank. It takes one read or write request at a time, each naming a row and a column. It then emits the precharge, activate and column commands the bank needs, spacing them by cycle counts set from parameters. A single-cycle response pulse marks the cycle in which the data would be valid. The pulse reports whether the access was a row hit, an access to an empty bank, or a row conflict.

The block records which row, if any, is latched in the row buffer. A policy input chooses how the row is closed. Under open-page policy the row stays latched after an access, and a precharge is issued only when a later request names a different row. Under close-page policy the bank is precharged right after every access. The policy is sampled when a request is accepted, so a change takes effect from the next request. The bank serves one request at a time and refuses new requests until it is idle again.

Top module: `bank_rowbuf_ctrl`

## Requirements
- R1: After reset the bank has no row open, `req_ready` is high, no command or response is driven, and the first accepted request is classified as empty.
- R2: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long, with `rsp_class` set to 01 for a row hit, 10 for an empty bank and 11 for a row conflict.
- R3: A request whose row equals the open row issues only a column command, one cycle after acceptance, and responds T_CAS cycles after that column command.
- R4: A request to a bank with no open row issues an activate one cycle after acceptance, then the column command T_RCD cycles after the activate, and responds T_CAS cycles after the column command.
- R5: A request to a row other than the open row issues a precharge one cycle after acceptance, an activate T_RP cycles after it, and then follows the R4 spacing. An activate is never issued while a row is open.
- R6: Under open-page policy (`policy_close`=0 at acceptance) the row stays open after the response, and `req_ready` returns one cycle after the response.
- R7: Under close-page policy (`policy_close`=1 at acceptance) a precharge is issued one cycle after the response, and `req_ready` returns T_RP cycles after that precharge with no row open.
- R8: `req_ready` is low from the cycle after acceptance until the bank is idle again. Requests presented in that interval are ignored and cause no commands.
- R9: `policy_close` is sampled only in the cycle a request is accepted. Changing it while the bank is busy does not change how the current request is handled.
- R10: `cmd_op` encodes 0 no command, 1 activate, 2 column read, 3 column write and 4 precharge. An activate carries the request row on `cmd_row`. A column command carries the request column on `cmd_col` and is a write exactly when `req_write` was set at acceptance.
- R11: When the bank is idle, `row_open` reports whether a row is latched and `open_row` reports which row it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_close | input | 1 | 1 selects close-page policy, 0 selects open-page policy |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bank idle and able to accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 3 | Command code (see R10) |
| cmd_row | output | ROW_W | Row of the current request |
| cmd_col | output | COL_W | Column of the current request |
| rsp_valid | output | 1 | Data of the current request would be valid this cycle |
| rsp_class | output | 2 | Hit, empty or conflict code (see R2) |
| row_open | output | 1 | A row is latched in the row buffer |
| open_row | output | ROW_W | Row held in the row buffer |

## Verification
A wrong open-row record shows up at the next request to the same bank. It appears as a wrong class code and as an activate or precharge that is missing or out of place, within one cycle of acceptance. A wrong timing count moves the column command or the response pulse, so every request exposes it at a fixed cycle offset. A stale policy value changes when `req_ready` returns and whether a closing precharge appears, one cycle after the response. The sweeps cover every ordered pair of rows under both policies, so each class follows each state of the row buffer.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        CLS_NONE     = 2'd0,
        CLS_HIT      = 2'd1,
        CLS_EMPTY    = 2'd2,
        CLS_CONFLICT = 2'd3
    } acc_class_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_PRE_W,
        S_ACT,
        S_ACT_W,
        S_COL,
        S_COL_W,
        S_RSP,
        S_CLOSE,
        S_CLOSE_W
    } seq_state_e;

    typedef struct packed {
        logic    valid;
        cmd_op_e op;
    } cmd_hdr_t;

    function automatic acc_class_e classify(input logic is_open, input logic same_row);
        if (!is_open)      return CLS_EMPTY;
        else if (same_row) return CLS_HIT;
        else               return CLS_CONFLICT;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rbp_wait_timer.sv
module rbp_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt_q == '0)); // R4

endmodule

// File: rtl/rbp_row_tracker.sv
module rbp_row_tracker
    import rbp_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_hdr_t         cmd,
    input  logic [ROW_W-1:0] cmd_row,
    input  logic [ROW_W-1:0] probe_row,
    output acc_class_e       probe_class,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (cmd.valid) begin
            case (cmd.op)
                CMD_ACT: begin
                    open_q <= 1'b1;
                    row_q  <= cmd_row;
                end
                CMD_PRE: open_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign probe_class = classify(open_q, row_q == probe_row);
    assign row_open    = open_q;
    assign open_row    = row_q;

    AST_ACT_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.op == CMD_ACT) |-> !open_q); // R5

    AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && (cmd.op == CMD_RD || cmd.op == CMD_WR))
            |-> (open_q && row_q == cmd_row)); // R3

endmodule

// File: rtl/rbp_sequencer.sv
module rbp_sequencer
    import rbp_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int T_RCD = 4,
    parameter int T_RP  = 4,
    parameter int T_CAS = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             policy_close,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    input  acc_class_e       probe_class,
    output cmd_hdr_t         cmd,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             rsp_valid,
    output acc_class_e       rsp_class,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    input  logic             tmr_last
);
    localparam logic [CNT_W-1:0] RP_WAIT  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RCD_WAIT = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] CAS_WAIT = CNT_W'(T_CAS - 1);
    localparam bit RP_MULTI  = (T_RP  > 1);
    localparam bit RCD_MULTI = (T_RCD > 1);
    localparam bit CAS_MULTI = (T_CAS > 1);

    seq_state_e       state_q, state_d;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             wr_q;
    logic             pol_q;
    acc_class_e       cls_q;
    logic             accept;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_ready && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            pol_q   <= 1'b0;
            cls_q   <= CLS_NONE;
        end else begin
            state_q <= state_d;
            if (accept) begin
                row_q <= req_row;
                col_q <= req_col;
                wr_q  <= req_write;
                pol_q <= policy_close;
                cls_q <= probe_class;
            end
        end
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            S_IDLE: begin
                if (accept) begin
                    case (probe_class)
                        CLS_HIT:   state_d = S_COL;
                        CLS_EMPTY: state_d = S_ACT;
                        default:   state_d = S_PRE;
                    endcase
                end
            end
            S_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = RP_WAIT;
                state_d  = RP_MULTI ? S_PRE_W : S_ACT;
            end
            S_PRE_W:   if (tmr_last) state_d = S_ACT;
            S_ACT: begin
                tmr_load = 1'b1;
                tmr_val  = RCD_WAIT;
                state_d  = RCD_MULTI ? S_ACT_W : S_COL;
            end
            S_ACT_W:   if (tmr_last) state_d = S_COL;
            S_COL: begin
                tmr_load = 1'b1;
                tmr_val  = CAS_WAIT;
                state_d  = CAS_MULTI ? S_COL_W : S_RSP;
            end
            S_COL_W:   if (tmr_last) state_d = S_RSP;
            S_RSP:     state_d = pol_q ? S_CLOSE : S_IDLE;
            S_CLOSE: begin
                tmr_load = 1'b1;
                tmr_val  = RP_WAIT;
                state_d  = RP_MULTI ? S_CLOSE_W : S_IDLE;
            end
            S_CLOSE_W: if (tmr_last) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_comb begin
        cmd.valid = 1'b1;
        case (state_q)
            S_PRE, S_CLOSE: cmd.op = CMD_PRE;
            S_ACT:          cmd.op = CMD_ACT;
            S_COL:          cmd.op = wr_q ? CMD_WR : CMD_RD;
            default: begin
                cmd.valid = 1'b0;
                cmd.op    = CMD_NOP;
            end
        endcase
    end

    assign cmd_row   = row_q;
    assign cmd_col   = col_q;
    assign rsp_valid = (state_q == S_RSP);
    assign rsp_class = rsp_valid ? cls_q : CLS_NONE;

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R2

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid || rsp_valid) |-> !req_ready); // R8

    AST_CLOSE_PRE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && pol_q) |=> (cmd.valid && cmd.op == CMD_PRE)); // R7

    AST_OPEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !pol_q) |=> req_ready); // R6

    AST_POLICY_HELD: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(pol_q)); // R9

endmodule

// File: rtl/bank_rowbuf_ctrl.sv
module bank_rowbuf_ctrl
    import rbp_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int T_RCD = 4,
    parameter int T_RP  = 4,
    parameter int T_CAS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             policy_close,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             rsp_valid,
    output logic [1:0]       rsp_class,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row
);
    localparam int T_MAX = max3(T_RCD, T_RP, T_CAS);
    localparam int CNT_W = $clog2(T_MAX + 1);

    cmd_hdr_t         cmd;
    acc_class_e       probe_class;
    acc_class_e       rsp_cls;
    logic             tmr_load;
    logic             tmr_last;
    logic [CNT_W-1:0] tmr_val;

    rbp_sequencer #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .T_RCD (T_RCD),
        .T_RP  (T_RP),
        .T_CAS (T_CAS),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .policy_close (policy_close),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_ready    (req_ready),
        .probe_class  (probe_class),
        .cmd          (cmd),
        .cmd_row      (cmd_row),
        .cmd_col      (cmd_col),
        .rsp_valid    (rsp_valid),
        .rsp_class    (rsp_cls),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .tmr_last     (tmr_last)
    );

    rbp_row_tracker #(
        .ROW_W (ROW_W)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .cmd_row     (cmd_row),
        .probe_row   (req_row),
        .probe_class (probe_class),
        .row_open    (row_open),
        .open_row    (open_row)
    );

    rbp_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    assign cmd_valid = cmd.valid;
    assign cmd_op    = cmd.op;
    assign rsp_class = rsp_cls;

endmodule

// File: tb/bank_rowbuf_ctrl_bench.sv
module bank_rowbuf_ctrl_bench;
    localparam int ROW_W = 2;
    localparam int COL_W = 3;
    localparam int T_RCD = 3;
    localparam int T_RP  = 2;
    localparam int T_CAS = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             policy_close;
    logic             req_valid;
    logic             req_ready;
    logic             req_write;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             cmd_valid;
    logic [2:0]       cmd_op;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             rsp_valid;
    logic [1:0]       rsp_class;
    logic             row_open;
    logic [ROW_W-1:0] open_row;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    bit       m_open = 0;
    int       m_row  = 0;
    bit       first_req = 1;

    always #2.5 clk = ~clk;

    bank_rowbuf_ctrl #(
        .ROW_W (ROW_W), .COL_W (COL_W),
        .T_RCD (T_RCD), .T_RP (T_RP), .T_CAS (T_CAS)
    ) u_bank_rowbuf_ctrl (
        .clk (clk), .rst (rst), .policy_close (policy_close),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_row (req_row), .req_col (req_col),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_row (cmd_row), .cmd_col (cmd_col),
        .rsp_valid (rsp_valid), .rsp_class (rsp_class),
        .row_open (row_open), .open_row (open_row)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_req(input int row, input int col, input bit wr, input bit pol, input bit junk);
        int exp_cls, e_pre, e_act, e_col, e_rsp, e_cpre, e_rdy, e_ncmd;
        int o_pre, o_act, o_col, o_rsp, o_cpre, o_rdy, o_ncmd, o_cls, o_rsps;
        bit bad_fields;
        o_pre = -1; o_act = -1; o_col = -1; o_rsp = -1; o_cpre = -1; o_rdy = -1;
        o_ncmd = 0; o_cls = 0; o_rsps = 0; bad_fields = 0;
        e_pre = -1; e_act = -1; e_cpre = -1;
        if (!m_open)          exp_cls = 2;
        else if (m_row == row) exp_cls = 1;
        else                   exp_cls = 3;
        if (exp_cls == 1) e_col = 1;
        else if (exp_cls == 2) begin e_act = 1; e_col = 1 + T_RCD; end
        else begin e_pre = 1; e_act = 1 + T_RP; e_col = e_act + T_RCD; end
        e_rsp = e_col + T_CAS;
        if (pol) begin e_cpre = e_rsp + 1; e_rdy = e_cpre + T_RP; end
        else e_rdy = e_rsp + 1;
        e_ncmd = 1 + (e_act > 0 ? 1 : 0) + (e_pre > 0 ? 1 : 0) + (pol ? 1 : 0);

        while (!req_ready) @(negedge clk);
        req_valid    = 1'b1;
        req_row      = ROW_W'(row);
        req_col      = COL_W'(col);
        req_write    = wr;
        policy_close = pol;
        @(negedge clk);
        for (int k = 1; k < 200; k++) begin
            if (cmd_valid) begin
                o_ncmd++;
                case (cmd_op)
                    3'd4: if (o_pre < 0 && k < e_rsp) o_pre = k; else o_cpre = k;
                    3'd1: begin
                        o_act = k;
                        if (int'(cmd_row) != row) bad_fields = 1;
                    end
                    3'd2, 3'd3: begin
                        o_col = k;
                        if (int'(cmd_col) != col) bad_fields = 1;
                        if ((cmd_op == 3'd3) != wr) bad_fields = 1;
                    end
                    default: bad_fields = 1;
                endcase
            end
            if (rsp_valid) begin
                o_rsps++;
                o_rsp = k;
                o_cls = int'(rsp_class);
            end
            if (req_ready) begin
                o_rdy = k;
                req_valid = 1'b0;
                break;
            end
            if (junk) begin
                req_valid    = 1'b1;
                req_row      = ROW_W'(row ^ 1);
                policy_close = ~pol;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end

        if (first_req) chk(o_cls == 2, "R1 first access class", o_cls, 2);
        first_req = 0;
        chk(o_cls == exp_cls, "R2 class code", o_cls, exp_cls);
        chk(o_rsps == 1, "R2 single response pulse", o_rsps, 1);
        if (exp_cls == 1) begin
            chk(o_col == e_col, "R3 hit column cycle", o_col, e_col);
            chk(o_rsp == e_rsp, "R3 hit response cycle", o_rsp, e_rsp);
            chk(o_act == -1, "R3 hit issues no activate", o_act, -1);
        end else if (exp_cls == 2) begin
            chk(o_act == e_act, "R4 empty activate cycle", o_act, e_act);
            chk(o_col == e_col, "R4 empty column cycle", o_col, e_col);
            chk(o_rsp == e_rsp, "R4 empty response cycle", o_rsp, e_rsp);
        end else begin
            chk(o_pre == e_pre, "R5 conflict precharge cycle", o_pre, e_pre);
            chk(o_act == e_act, "R5 conflict activate cycle", o_act, e_act);
            chk(o_col == e_col, "R5 conflict column cycle", o_col, e_col);
            chk(o_rsp == e_rsp, "R5 conflict response cycle", o_rsp, e_rsp);
        end
        if (pol) begin
            chk(o_cpre == e_cpre, "R7 closing precharge cycle", o_cpre, e_cpre);
            chk(o_rdy == e_rdy, "R7 ready after close", o_rdy, e_rdy);
            chk(row_open == 1'b0, "R7 no row open after close", int'(row_open), 0);
        end else begin
            chk(o_rdy == e_rdy, "R6 ready after open access", o_rdy, e_rdy);
            chk(row_open == 1'b1, "R6 row kept open", int'(row_open), 1);
        end
        chk(o_ncmd == e_ncmd, "R8 command count with busy requests", o_ncmd, e_ncmd);
        if (junk) chk(o_rdy == e_rdy, "R9 policy toggled while busy", o_rdy, e_rdy);
        chk(!bad_fields, "R10 command fields", int'(bad_fields), 0);
        if (!pol) chk(int'(open_row) == row, "R11 open row reported", int'(open_row), row);

        if (pol) m_open = 0;
        else begin m_open = 1; m_row = row; end
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        policy_close = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_row = '0;
        req_col = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(row_open == 1'b0, "R1 no row open after reset", int'(row_open), 0);
        chk(cmd_valid == 1'b0, "R1 no command after reset", int'(cmd_valid), 0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 4; r++)
                for (int w = 0; w < 2; w++)
                    do_req(r, (r * 2 + w) & 7, w[0], p[0], w[0]);

        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                do_req(a, a + b, 1'b0, 1'b0, 1'b0);
                do_req(b, 7 - b, 1'b1, 1'b0, 1'b1);
                do_req(b, a, b[0], 1'b1, a[0]);
            end

        for (int i = 0; i < 24; i++)
            do_req((i * 3) & 3, i & 7, i[1], i[2] ^ i[0], i[0]);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule